// File: doc/BRIEF.md
# Debug Hart Run-Control and Status

This block is the run-control front of a debug controller. A debugger reaches it through a simple register port carrying a control register and a status register. A hart-select field in the control register names one hart. Halt and resume requests written by the debugger act on that hart, and the status register summarizes that hart's state. A select value past the last implemented hart names a hart that does not exist.

Each hart holds its own state: a halt request, a resume flag, a resume acknowledge, a halted bit and a go flag. The debugger sets the resume flag, and the hart clears it with a "resuming" strobe. That same strobe raises the acknowledge. The hart also reports entry into debug with a "halted" strobe. A launch input arms the go flag of the selected hart, and a "going" strobe clears it. The block also drives reset requests to the harts: one to every hart, or one to the selected hart only. How the harts sequence their own reset is outside this block.

Top module: `dbg_runctl`

## Requirements
- R1: After reset, every halt request, resume flag, go flag and hart reset output is 0, and the control register (address 0x10) reads 0. The status register (address 0x11) reads version 2 in bits [3:0], authenticated in bit 7, an implicit breakpoint in bit 22, and the summary bits for hart 0. The summary bits are anyhalted 8, allhalted 9, anyrunning 10, allrunning 11, anynonexistent 14, allnonexistent 15, anyresumeack 16 and allresumeack 17.
- R2: The control register fields are active in bit 0, ndmreset in bit 1, hart select in [16 +: SEL_W], hartreset in bit 29, resumereq in bit 30 and haltreq in bit 31. A write with bit 0 clear updates only the active bit. Halt requests, the select field, the reset fields and resumereq all keep their values.
- R3: A live control write (bit 0 set) loads haltreq into the halt request of the written hart only. Reading bit 31 of the control register returns the halt request of the selected hart.
- R4: A live write with resumereq=1 sets the written hart's resume flag and clears its resume acknowledge.
- R5: A "resuming" strobe from a hart sets its acknowledge, clears its resume flag and clears its halted state.
- R6: A "halted" strobe marks the hart halted. A halted selected hart reads allhalted=1 and allrunning=0. An existing hart that is not halted reads allrunning=1.
- R7: The launch input sets the go flag of the currently selected hart. A "going" strobe clears the go flag of the currently selected hart only.
- R8: If the select value is NUM_HARTS or more, allnonexistent reads 1 and the halted, running and resumeack bits read 0. A halt written to such a hart changes no halt request.
- R9: Each "any" summary bit equals its matching "all" bit.
- R10: While ndmreset is held, every hart reset output is 1. While hartreset is held, only the selected hart's reset output is 1.
- R11: When a resumereq write and a "resuming" strobe hit the same hart in the same cycle, the write wins: the flag ends set and the acknowledge ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_valid_i | input | 1 | Register access valid |
| reg_write_i | input | 1 | Access is a write |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| hart_halted_i | input | NUM_HARTS | Per-hart strobe: hart entered debug |
| hart_resuming_i | input | NUM_HARTS | Per-hart strobe: hart is resuming |
| hart_going_i | input | 1 | Strobe: selected hart picked up its go flag |
| go_launch_i | input | 1 | Arm the go flag of the selected hart |
| halt_req_o | output | NUM_HARTS | Per-hart halt request |
| resume_flag_o | output | NUM_HARTS | Per-hart resume flag |
| go_flag_o | output | NUM_HARTS | Per-hart go flag |
| hart_reset_o | output | NUM_HARTS | Per-hart reset request |

## Verification
The bench writes to a hart and then moves the selection away from it. A design that aimed halt or resume at every hart, or kept stale state under the old select value, would show wrong halt request vectors or a wrong summary. Writes with the active bit clear must leave the select field and the halt requests alone. A design that ignored the gating would move the selection or raise a halt. The bench selects a hart past the last one, where a design that indexed without checking range would report a running or halted hart instead of a missing one. It also fires a resumereq write and a resuming strobe at the same hart in the same cycle. A design with the wrong priority would drop the flag or leave a stale acknowledge.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;

  localparam int unsigned REG_W = 32;

  // control register bit positions
  localparam int CB_ACTIVE  = 0;
  localparam int CB_NDM     = 1;
  localparam int CB_SEL_LSB = 16;
  localparam int CB_HRESET  = 29;
  localparam int CB_RESUME  = 30;
  localparam int CB_HALT    = 31;

  // status register bit positions
  localparam int SB_AUTH    = 7;
  localparam int SB_ANYHALT = 8;
  localparam int SB_ALLHALT = 9;
  localparam int SB_ANYRUN  = 10;
  localparam int SB_ALLRUN  = 11;
  localparam int SB_ANYNX   = 14;
  localparam int SB_ALLNX   = 15;
  localparam int SB_ANYACK  = 16;
  localparam int SB_ALLACK  = 17;
  localparam int SB_IMPEB   = 22;
  localparam logic [3:0] STAT_VERSION = 4'd2;

  typedef struct packed {
    logic halt;
    logic resume;
    logic hreset;
    logic ndm;
    logic active;
  } ctrl_bits_t;

  typedef struct packed {
    logic nonexist;
    logic running;
    logic halted;
    logic resack;
  } hart_view_t;

  function automatic ctrl_bits_t decode_ctrl(input logic [REG_W-1:0] w);
    ctrl_bits_t c;
    c.halt   = w[CB_HALT];
    c.resume = w[CB_RESUME];
    c.hreset = w[CB_HRESET];
    c.ndm    = w[CB_NDM];
    c.active = w[CB_ACTIVE];
    return c;
  endfunction

  function automatic hart_view_t summarize(input logic exists, input logic halted,
                                           input logic ack);
    hart_view_t v;
    v.nonexist = !exists;
    v.running  = exists && !halted;
    v.halted   = exists && halted;
    v.resack   = exists && ack;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input hart_view_t v);
    logic [REG_W-1:0] w;
    w = '0;
    w[3:0]       = STAT_VERSION;
    w[SB_AUTH]   = 1'b1;
    w[SB_IMPEB]  = 1'b1;
    w[SB_ANYHALT] = v.halted;
    w[SB_ALLHALT] = v.halted;
    w[SB_ANYRUN]  = v.running;
    w[SB_ALLRUN]  = v.running;
    w[SB_ANYNX]   = v.nonexist;
    w[SB_ALLNX]   = v.nonexist;
    w[SB_ANYACK]  = v.resack;
    w[SB_ALLACK]  = v.resack;
    return w;
  endfunction

endpackage

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
  import dbg_runctl_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 7,
  parameter int CTRL_ADDR = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              ctrl_wr_o,
  output logic              wr_live_o,
  output ctrl_bits_t        wr_bits_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic              active_q_o,
  output logic              ndm_q_o,
  output logic              hreset_q_o,
  output logic              resume_q_o,
  output logic [SEL_W-1:0]  sel_q_o
);

  ctrl_bits_t bits;

  assign bits      = decode_ctrl(reg_wdata_i);
  assign ctrl_wr_o = reg_valid_i && reg_write_i && (reg_addr_i == ADDR_W'(CTRL_ADDR));
  assign wr_live_o = ctrl_wr_o && bits.active;
  assign wr_bits_o = bits;
  assign wr_sel_o  = reg_wdata_i[CB_SEL_LSB +: SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q_o <= 1'b0;
      ndm_q_o    <= 1'b0;
      hreset_q_o <= 1'b0;
      resume_q_o <= 1'b0;
      sel_q_o    <= '0;
    end else if (ctrl_wr_o) begin
      active_q_o <= bits.active;
      if (bits.active) begin
        ndm_q_o    <= bits.ndm;
        hreset_q_o <= bits.hreset;
        resume_q_o <= bits.resume;
        sel_q_o    <= wr_sel_o;
      end
    end
  end

endmodule

// File: rtl/dbg_hart_state.sv
module dbg_hart_state
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int SEL_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_live_i,
  input  ctrl_bits_t           wr_bits_i,
  input  logic [SEL_W-1:0]     wr_sel_i,
  input  logic [SEL_W-1:0]     sel_q_i,
  input  logic                 ndm_q_i,
  input  logic                 hreset_q_i,
  input  logic [NUM_HARTS-1:0] halted_stb_i,
  input  logic [NUM_HARTS-1:0] resuming_stb_i,
  input  logic                 going_i,
  input  logic                 launch_i,
  output logic [NUM_HARTS-1:0] resume_hit_o,
  output logic [NUM_HARTS-1:0] halt_req_o,
  output logic [NUM_HARTS-1:0] resume_flag_o,
  output logic [NUM_HARTS-1:0] resume_ack_o,
  output logic [NUM_HARTS-1:0] halted_o,
  output logic [NUM_HARTS-1:0] go_flag_o,
  output logic [NUM_HARTS-1:0] hart_reset_o
);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic sel_now, sel_wr, hit;
    logic halt_q, flag_q, ack_q, halted_q, go_q;

    assign sel_now = (sel_q_i == SEL_W'(h));
    assign sel_wr  = wr_live_i && (wr_sel_i == SEL_W'(h));
    assign hit     = sel_wr && wr_bits_i.resume;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        halt_q   <= 1'b0;
        flag_q   <= 1'b0;
        ack_q    <= 1'b0;
        halted_q <= 1'b0;
        go_q     <= 1'b0;
      end else begin
        if (sel_wr) halt_q <= wr_bits_i.halt;
        // debugger write outranks the hart strobe
        if (hit)                    flag_q <= 1'b1;
        else if (resuming_stb_i[h]) flag_q <= 1'b0;
        if (hit)                    ack_q  <= 1'b0;
        else if (resuming_stb_i[h]) ack_q  <= 1'b1;
        if (resuming_stb_i[h])      halted_q <= 1'b0;
        else if (halted_stb_i[h])   halted_q <= 1'b1;
        if (going_i && sel_now)       go_q <= 1'b0;
        else if (launch_i && sel_now) go_q <= 1'b1;
      end
    end

    assign resume_hit_o[h]  = hit;
    assign halt_req_o[h]    = halt_q;
    assign resume_flag_o[h] = flag_q;
    assign resume_ack_o[h]  = ack_q;
    assign halted_o[h]      = halted_q;
    assign go_flag_o[h]     = go_q;
    assign hart_reset_o[h]  = ndm_q_i | (hreset_q_i & sel_now);
  end

endmodule

// File: rtl/dbg_status_view.sv
module dbg_status_view
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int SEL_W     = 4
) (
  input  logic [SEL_W-1:0]     sel_q_i,
  input  logic                 active_q_i,
  input  logic                 ndm_q_i,
  input  logic                 hreset_q_i,
  input  logic                 resume_q_i,
  input  logic [NUM_HARTS-1:0] halt_req_i,
  input  logic [NUM_HARTS-1:0] halted_i,
  input  logic [NUM_HARTS-1:0] resume_ack_i,
  output logic                 sel_exists_o,
  output logic [REG_W-1:0]     stat_word_o,
  output logic [REG_W-1:0]     ctrl_word_o
);

  logic halted_sel, ack_sel, halt_sel;

  assign sel_exists_o = (32'(sel_q_i) < 32'(NUM_HARTS));

  always_comb begin
    halted_sel = 1'b0;
    ack_sel    = 1'b0;
    halt_sel   = 1'b0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (sel_q_i == SEL_W'(h)) begin
        halted_sel = halted_i[h];
        ack_sel    = resume_ack_i[h];
        halt_sel   = halt_req_i[h];
      end
    end
  end

  assign stat_word_o = pack_status(summarize(sel_exists_o, halted_sel, ack_sel));

  always_comb begin
    ctrl_word_o = '0;
    ctrl_word_o[CB_ACTIVE]            = active_q_i;
    ctrl_word_o[CB_NDM]               = ndm_q_i;
    ctrl_word_o[CB_SEL_LSB +: SEL_W]  = sel_q_i;
    ctrl_word_o[CB_HRESET]            = hreset_q_i;
    ctrl_word_o[CB_RESUME]            = resume_q_i;
    ctrl_word_o[CB_HALT]              = halt_sel;
  end

endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 7,
  parameter int CTRL_ADDR = 'h10,
  parameter int STAT_ADDR = 'h11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_valid_i,
  input  logic                 reg_write_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NUM_HARTS-1:0] hart_halted_i,
  input  logic [NUM_HARTS-1:0] hart_resuming_i,
  input  logic                 hart_going_i,
  input  logic                 go_launch_i,
  output logic [NUM_HARTS-1:0] halt_req_o,
  output logic [NUM_HARTS-1:0] resume_flag_o,
  output logic [NUM_HARTS-1:0] go_flag_o,
  output logic [NUM_HARTS-1:0] hart_reset_o
);

  // named internal events, also observed by the checker
  logic                 ctrl_wr, wr_live;
  ctrl_bits_t           wr_bits;
  logic [SEL_W-1:0]     wr_sel, sel_q;
  logic                 active_q, ndm_q, hreset_q, resume_q;
  logic [NUM_HARTS-1:0] resume_hit, resume_ack, halted_q;
  logic                 sel_exists;
  logic [REG_W-1:0]     stat_word, ctrl_word;

  dbg_ctrl_regs #(
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk_i, .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i,
    .ctrl_wr_o(ctrl_wr), .wr_live_o(wr_live), .wr_bits_o(wr_bits),
    .wr_sel_o(wr_sel), .active_q_o(active_q), .ndm_q_o(ndm_q),
    .hreset_q_o(hreset_q), .resume_q_o(resume_q), .sel_q_o(sel_q)
  );

  dbg_hart_state #(
    .NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W)
  ) u_harts (
    .clk_i, .rst_ni,
    .wr_live_i(wr_live), .wr_bits_i(wr_bits), .wr_sel_i(wr_sel),
    .sel_q_i(sel_q), .ndm_q_i(ndm_q), .hreset_q_i(hreset_q),
    .halted_stb_i(hart_halted_i), .resuming_stb_i(hart_resuming_i),
    .going_i(hart_going_i), .launch_i(go_launch_i),
    .resume_hit_o(resume_hit), .halt_req_o(halt_req_o),
    .resume_flag_o(resume_flag_o), .resume_ack_o(resume_ack),
    .halted_o(halted_q), .go_flag_o(go_flag_o), .hart_reset_o(hart_reset_o)
  );

  dbg_status_view #(
    .NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W)
  ) u_view (
    .sel_q_i(sel_q), .active_q_i(active_q), .ndm_q_i(ndm_q),
    .hreset_q_i(hreset_q), .resume_q_i(resume_q),
    .halt_req_i(halt_req_o), .halted_i(halted_q), .resume_ack_i(resume_ack),
    .sel_exists_o(sel_exists), .stat_word_o(stat_word), .ctrl_word_o(ctrl_word)
  );

  always_comb begin
    if (reg_addr_i == ADDR_W'(CTRL_ADDR))      reg_rdata_o = ctrl_word;
    else if (reg_addr_i == ADDR_W'(STAT_ADDR)) reg_rdata_o = stat_word;
    else                                       reg_rdata_o = '0;
  end

endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ctrl_wr,
  input logic                 wr_live,
  input logic                 sel_exists,
  input logic                 ndm_q,
  input logic [REG_W-1:0]     stat_word,
  input logic [NUM_HARTS-1:0] resume_hit,
  input logic [NUM_HARTS-1:0] resume_ack,
  input logic [NUM_HARTS-1:0] hart_resuming_i,
  input logic [NUM_HARTS-1:0] resume_flag_o,
  input logic [NUM_HARTS-1:0] halt_req_o,
  input logic [NUM_HARTS-1:0] hart_reset_o
);

  AST_ANY_MATCHES_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_word[SB_ANYHALT] == stat_word[SB_ALLHALT] && stat_word[SB_ANYRUN] == stat_word[SB_ALLRUN] &&
    stat_word[SB_ANYNX] == stat_word[SB_ALLNX] && stat_word[SB_ANYACK] == stat_word[SB_ALLACK]); // R9

  AST_HALT_RUN_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stat_word[SB_ALLHALT] && stat_word[SB_ALLRUN])); // R6

  AST_NONEXIST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_exists |-> stat_word[SB_ALLNX] && !stat_word[SB_ALLHALT] &&
                    !stat_word[SB_ALLRUN] && !stat_word[SB_ALLACK]); // R8

  AST_INACTIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !wr_live |=> $stable(halt_req_o)); // R2

  AST_NDM_ALL_HARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ndm_q |-> &hart_reset_o); // R10

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
    AST_RESUMING_ACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hart_resuming_i[h] && !resume_hit[h] |=> resume_ack[h] && !resume_flag_o[h]); // R5
    AST_RESUME_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resume_hit[h] |=> resume_flag_o[h] && !resume_ack[h]); // R4 R11
  end

endmodule

bind dbg_runctl dbg_runctl_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr(ctrl_wr), .wr_live(wr_live),
  .sel_exists(sel_exists), .ndm_q(ndm_q), .stat_word(stat_word),
  .resume_hit(resume_hit), .resume_ack(resume_ack),
  .hart_resuming_i(hart_resuming_i), .resume_flag_o(resume_flag_o),
  .halt_req_o(halt_req_o), .hart_reset_o(hart_reset_o)
);

// File: tb/dbg_runctl_tb_top.sv
module dbg_runctl_tb_top;

  localparam int N = 4;
  localparam logic [6:0] A_CTRL = 7'h10;
  localparam logic [6:0] A_STAT = 7'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, wr = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] halted_s = '0, resuming_s = '0;
  logic going = 1'b0, launch = 1'b0;
  logic [N-1:0] halt_req, res_flag, go_flag, hreset;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_runctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(valid), .reg_write_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .hart_halted_i(halted_s), .hart_resuming_i(resuming_s),
    .hart_going_i(going), .go_launch_i(launch),
    .halt_req_o(halt_req), .resume_flag_o(res_flag),
    .go_flag_o(go_flag), .hart_reset_o(hreset)
  );

  function automatic logic [31:0] cw(bit act, bit halt, bit res, bit hrst, bit ndm, int sel);
    logic [31:0] w = '0;
    w[0] = act; w[1] = ndm; w[29] = hrst; w[30] = res; w[31] = halt;
    w[19:16] = sel[3:0];
    return w;
  endfunction

  function automatic logic [31:0] st(bit exists, bit hlt, bit ack);
    logic [31:0] w = 32'h2 | (32'h1 << 7) | (32'h1 << 22);
    if (!exists) w |= (32'h3 << 14);
    else if (hlt) w |= (32'h3 << 8);
    else w |= (32'h3 << 10);
    if (exists && ack) w |= (32'h3 << 16);
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_reg(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(logic [6:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(logic [N-1:0] hs, logic [N-1:0] rs, bit gg, bit ll);
    @(negedge clk);
    halted_s = hs; resuming_s = rs; going = gg; launch = ll;
    @(negedge clk);
    halted_s = '0; resuming_s = '0; going = 1'b0; launch = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd_reg(A_STAT, d); chk("R1 status", d, st(1, 0, 0));
    chk("R1 outputs", {16'h0, halt_req, res_flag, go_flag, hreset}, 32'h0);
  endtask

  task automatic t_halt_select();
    logic [31:0] d;
    wr_reg(A_CTRL, cw(1, 1, 0, 0, 0, 2));
    chk("R3 halt hart2", {28'h0, halt_req}, 32'h4);
    rd_reg(A_CTRL, d); chk("R3 readback", d, 32'h8002_0001);
    wr_reg(A_CTRL, cw(1, 1, 0, 0, 0, 1));
    chk("R3 halt hart1 keeps hart2", {28'h0, halt_req}, 32'h6);
    wr_reg(A_CTRL, cw(1, 0, 0, 0, 0, 2));
    chk("R3 release hart2", {28'h0, halt_req}, 32'h2);
  endtask

  task automatic t_inactive();
    logic [31:0] d;
    wr_reg(A_CTRL, cw(0, 1, 1, 1, 1, 3));
    chk("R2 halt unchanged", {28'h0, halt_req}, 32'h2);
    chk("R2 no reset", {28'h0, hreset}, 32'h0);
    rd_reg(A_CTRL, d); chk("R2 fields held", d, 32'h0002_0000);
  endtask

  task automatic t_resume();
    logic [31:0] d;
    wr_reg(A_CTRL, cw(1, 0, 1, 0, 0, 1));
    chk("R4 flag set", {28'h0, res_flag}, 32'h2);
    rd_reg(A_STAT, d); chk("R4 ack clear", d, st(1, 0, 0));
    pulse('0, 4'b0010, 0, 0);
    chk("R5 flag cleared", {28'h0, res_flag}, 32'h0);
    rd_reg(A_STAT, d); chk("R5 ack set R9", d, st(1, 0, 1));
  endtask

  task automatic t_halted();
    logic [31:0] d;
    pulse(4'b1000, '0, 0, 0);
    wr_reg(A_CTRL, cw(1, 0, 0, 0, 0, 3));
    rd_reg(A_STAT, d); chk("R6 halted R9", d, st(1, 1, 0));
    pulse('0, 4'b1000, 0, 0);
    rd_reg(A_STAT, d); chk("R6 running after resuming", d, st(1, 0, 1));
  endtask

  task automatic t_go();
    pulse('0, '0, 0, 1);
    chk("R7 launch hart3", {28'h0, go_flag}, 32'h8);
    wr_reg(A_CTRL, cw(1, 0, 0, 0, 0, 0));
    pulse('0, '0, 0, 1);
    chk("R7 launch hart0", {28'h0, go_flag}, 32'h9);
    pulse('0, '0, 1, 0);
    chk("R7 going clears selected only", {28'h0, go_flag}, 32'h8);
  endtask

  task automatic t_nonexist();
    logic [31:0] d;
    wr_reg(A_CTRL, cw(1, 0, 0, 0, 0, 9));
    rd_reg(A_STAT, d); chk("R8 nonexistent R9", d, st(0, 0, 0));
    wr_reg(A_CTRL, cw(1, 1, 0, 0, 0, 9));
    chk("R8 halt to missing hart", {28'h0, halt_req}, 32'h0);
    rd_reg(A_CTRL, d); chk("R8 readback", d, 32'h0009_0001);
  endtask

  task automatic t_resets();
    wr_reg(A_CTRL, cw(1, 0, 0, 0, 1, 0));
    chk("R10 ndmreset all", {28'h0, hreset}, 32'hF);
    wr_reg(A_CTRL, cw(1, 0, 0, 1, 0, 2));
    chk("R10 hartreset selected", {28'h0, hreset}, 32'h4);
    wr_reg(A_CTRL, cw(1, 0, 0, 0, 0, 2));
    chk("R10 released", {28'h0, hreset}, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    @(negedge clk);
    valid = 1'b1; wr = 1'b1; addr = A_CTRL; wdata = cw(1, 0, 1, 0, 0, 1);
    resuming_s = 4'b0010;
    @(negedge clk);
    valid = 1'b0; wr = 1'b0; resuming_s = '0;
    chk("R11 flag wins", {28'h0, res_flag}, 32'h2);
    rd_reg(A_STAT, d); chk("R11 ack cleared", d, st(1, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt_select();
    t_inactive();
    t_resume();
    t_halted();
    t_go();
    t_nonexist();
    t_resets();
    t_same_cycle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule